// File: doc/BRIEF.md
# Parallel NOR Flash Command Sequence Decoder

This block is the command interpreter of a x16 parallel NOR flash, written as synchronous logic that works on a sampled copy of the asynchronous bus. It sees chip enable, write enable and output enable, a 19-bit address and a 16-bit data word. From these it forms write cycles. Each cycle takes the address present when the write window opens and the data present just before the window closes. The cycles then pass to a sequence engine that knows the keyed unlock patterns.

When a keyed pattern completes, the block emits a one-cycle start pulse to the operation timer. The pulse carries an operation code, an aligned target address and the data word of the final write. The block also tracks whether the device is in normal read, identification or query mode. Any cycle that breaks a sequence sends the decoder back to read mode with its position reset. While the operation timer reports busy, every write is dropped.

Top module: `nor_cmd_decoder`

## Requirements
- R1: After reset, mode is read (00), start_pulse is low, and the sequence position is zero, so a lone write to any address starts nothing.
- R2: Unlock cycles compare only address bits 14..0 (against 5555h or 2AAAh) and data bits 7..0; address bits 18..15 and data bits 15..8 are ignored.
- R3: The writes AAh@5555h, 55h@2AAAh, A0h@5555h followed by any fourth write produce a start pulse with op 00 (program), tgt_addr equal to the full fourth-write address and tgt_data equal to the fourth-write data.
- R4: The writes AAh@5555h, 55h@2AAAh, 80h@5555h, AAh@5555h, 55h@2AAAh, 10h@5555h produce op 11 (chip erase) with tgt_addr 0; a final 10h to another address starts nothing.
- R5: The same five-cycle erase prefix followed by 30h produces op 01 (sector erase) with tgt_addr bits 10..0 cleared; followed by 50h it produces op 10 (block erase) with tgt_addr bits 14..0 cleared.
- R6: AAh@5555h, 55h@2AAAh, 90h@5555h sets mode 01 (identification). The same sequence ending in 98h sets mode 10 (query), and so does a single write of 98h to address 0055h from the start of a sequence.
- R7: A single write of F0h to any address, or the sequence AAh@5555h, 55h@2AAAh, F0h@5555h, returns mode to read (00).
- R8: A cycle that matches no allowed next step returns mode to read and the position to zero, so the next complete valid sequence works normally.
- R9: While busy is high, every write is ignored: it starts no operation, changes no mode, and does not move the sequence position.
- R10: A write cycle exists only while chip enable is low, write enable is low and output enable is high; a strobe made with output enable low neither advances nor aborts a sequence.
- R11: The address of a write is the one present when the later of chip enable and write enable falls. The data is the one present just before the earlier of the two rises.
- R12: start_pulse is high for exactly one clock cycle. It rises after the third rising clock edge that follows the end of the final write strobe.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ce_n | input | 1 | Chip enable, active low |
| we_n | input | 1 | Write enable, active low |
| oe_n | input | 1 | Output enable, active low |
| addr | input | 19 | Bus address |
| data | input | 16 | Bus write data |
| busy | input | 1 | Internal operation in progress, from the operation timer |
| start_pulse | output | 1 | One-cycle operation start |
| start_op | output | 2 | 00 program, 01 sector erase, 10 block erase, 11 chip erase |
| tgt_addr | output | 19 | Latched, aligned target address |
| tgt_data | output | 16 | Data word of the final write |
| mode | output | 2 | 00 read, 01 identification, 10 query |

## Verification
The hardest case to reach from the ports is the capture rule. The address must come from the moment the write window opens and the data from the moment it closes, and a plain write task never tells these apart. The stimulus therefore opens chip enable first with a decoy address, then lowers write enable with the real address. It changes the address and data again while the window is open, and it ends the window on write enable. The scoreboard then expects the second address and the last data word. A second hard case is a strobe made with output enable low, placed in the middle of a program sequence. It must be neither counted nor treated as an abort, so the sequence completes only if the strobe was truly ignored.

// File: rtl/nor_cmd_pkg.sv
package nor_cmd_pkg;

  localparam int CMP_W = 15;

  localparam logic [CMP_W-1:0] KEY_ADDR_A = 15'h5555;
  localparam logic [CMP_W-1:0] KEY_ADDR_B = 15'h2AAA;
  localparam logic [CMP_W-1:0] QRY_ADDR   = 15'h0055;

  localparam logic [7:0] KEY_DAT_A   = 8'hAA;
  localparam logic [7:0] KEY_DAT_B   = 8'h55;
  localparam logic [7:0] CMD_PROG    = 8'hA0;
  localparam logic [7:0] CMD_ERASE   = 8'h80;
  localparam logic [7:0] CMD_SECT    = 8'h30;
  localparam logic [7:0] CMD_BLK     = 8'h50;
  localparam logic [7:0] CMD_CHIP    = 8'h10;
  localparam logic [7:0] CMD_ID      = 8'h90;
  localparam logic [7:0] CMD_QUERY   = 8'h98;
  localparam logic [7:0] CMD_EXIT    = 8'hF0;

  typedef enum logic [1:0] {
    OP_PROG = 2'b00,
    OP_SECT = 2'b01,
    OP_BLK  = 2'b10,
    OP_CHIP = 2'b11
  } op_e;

  typedef enum logic [1:0] {
    MODE_READ  = 2'b00,
    MODE_ID    = 2'b01,
    MODE_QUERY = 2'b10
  } mode_e;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_K1,
    ST_K2,
    ST_PWORD,
    ST_E3,
    ST_E4,
    ST_E5
  } seq_e;

endpackage

// File: rtl/nor_bus_sampler.sv
module nor_bus_sampler #(
  parameter int ADDR_W = 19,
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              ce_n,
  input  logic              we_n,
  input  logic              oe_n,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] data,
  output logic              wr_vld,
  output logic [ADDR_W-1:0] wr_addr,
  output logic [DATA_W-1:0] wr_data
);

  logic              s_ce_n, s_we_n, s_oe_n;
  logic [ADDR_W-1:0] s_addr;
  logic [DATA_W-1:0] s_data;
  logic              win, win_q;
  logic              closed_by_strobe;

  // one register stage on every bus pin
  always_ff @(posedge clk) begin
    if (rst) begin
      s_ce_n <= 1'b1;
      s_we_n <= 1'b1;
      s_oe_n <= 1'b1;
      s_addr <= '0;
      s_data <= '0;
    end else begin
      s_ce_n <= ce_n;
      s_we_n <= we_n;
      s_oe_n <= oe_n;
      s_addr <= addr;
      s_data <= data;
    end
  end

  // write window: both strobes low, output drivers off
  assign win              = !s_ce_n && !s_we_n && s_oe_n;
  assign closed_by_strobe = s_ce_n || s_we_n;

  always_ff @(posedge clk) begin
    if (rst) begin
      win_q   <= 1'b0;
      wr_vld  <= 1'b0;
      wr_addr <= '0;
      wr_data <= '0;
    end else begin
      win_q  <= win;
      wr_vld <= win_q && !win && closed_by_strobe;
      if (win && !win_q)
        wr_addr <= s_addr;
      if (win)
        wr_data <= s_data;
    end
  end

endmodule

// File: rtl/nor_tgt_align.sv
module nor_tgt_align
  import nor_cmd_pkg::*;
#(
  parameter int ADDR_W   = 19,
  parameter int SECT_LSB = 11,
  parameter int BLK_LSB  = 15
) (
  input  op_e               op,
  input  logic [ADDR_W-1:0] addr_in,
  output logic [ADDR_W-1:0] addr_out
);

  localparam logic [ADDR_W-1:0] SECT_MASK = {ADDR_W{1'b1}} << SECT_LSB;
  localparam logic [ADDR_W-1:0] BLK_MASK  = {ADDR_W{1'b1}} << BLK_LSB;

  always_comb begin
    unique case (op)
      OP_PROG: addr_out = addr_in;
      OP_SECT: addr_out = addr_in & SECT_MASK;
      OP_BLK:  addr_out = addr_in & BLK_MASK;
      default: addr_out = '0;
    endcase
  end

endmodule

// File: rtl/nor_seq_fsm.sv
module nor_seq_fsm
  import nor_cmd_pkg::*;
#(
  parameter int ADDR_W   = 19,
  parameter int DATA_W   = 16,
  parameter int SECT_LSB = 11,
  parameter int BLK_LSB  = 15
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_vld,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              busy,
  output logic              start_pulse,
  output op_e               start_op,
  output logic [ADDR_W-1:0] tgt_addr,
  output logic [DATA_W-1:0] tgt_data,
  output mode_e             mode
);

  seq_e              st;
  logic              at_a, at_b, at_q;
  logic [7:0]        cmd;
  op_e               erase_op;
  logic              erase_ok;
  logic [ADDR_W-1:0] erase_addr;

  assign at_a = wr_addr[CMP_W-1:0] == KEY_ADDR_A;
  assign at_b = wr_addr[CMP_W-1:0] == KEY_ADDR_B;
  assign at_q = wr_addr[CMP_W-1:0] == QRY_ADDR;
  assign cmd  = wr_data[7:0];

  // decode of the sixth erase cycle
  always_comb begin
    erase_op = OP_CHIP;
    erase_ok = 1'b0;
    if (cmd == CMD_SECT) begin
      erase_op = OP_SECT;
      erase_ok = 1'b1;
    end else if (cmd == CMD_BLK) begin
      erase_op = OP_BLK;
      erase_ok = 1'b1;
    end else if (cmd == CMD_CHIP && at_a) begin
      erase_op = OP_CHIP;
      erase_ok = 1'b1;
    end
  end

  nor_tgt_align #(
    .ADDR_W  (ADDR_W),
    .SECT_LSB(SECT_LSB),
    .BLK_LSB (BLK_LSB)
  ) u_align (
    .op      (erase_op),
    .addr_in (wr_addr),
    .addr_out(erase_addr)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      st          <= ST_IDLE;
      mode        <= MODE_READ;
      start_pulse <= 1'b0;
      start_op    <= OP_PROG;
      tgt_addr    <= '0;
      tgt_data    <= '0;
    end else begin
      start_pulse <= 1'b0;
      if (wr_vld && !busy) begin
        // default: any cycle that fits no step aborts to read
        st   <= ST_IDLE;
        mode <= MODE_READ;
        unique case (st)
          ST_IDLE: begin
            if (at_a && cmd == KEY_DAT_A) begin
              st   <= ST_K1;
              mode <= mode;
            end else if (at_q && cmd == CMD_QUERY) begin
              mode <= MODE_QUERY;
            end
          end
          ST_K1: begin
            if (at_b && cmd == KEY_DAT_B) begin
              st   <= ST_K2;
              mode <= mode;
            end
          end
          ST_K2: begin
            if (at_a) begin
              unique case (cmd)
                CMD_PROG:  begin st <= ST_PWORD; mode <= mode; end
                CMD_ERASE: begin st <= ST_E3;    mode <= mode; end
                CMD_ID:    mode <= MODE_ID;
                CMD_QUERY: mode <= MODE_QUERY;
                default:   mode <= MODE_READ;
              endcase
            end
          end
          ST_PWORD: begin
            start_pulse <= 1'b1;
            start_op    <= OP_PROG;
            tgt_addr    <= wr_addr;
            tgt_data    <= wr_data;
          end
          ST_E3: begin
            if (at_a && cmd == KEY_DAT_A) begin
              st   <= ST_E4;
              mode <= mode;
            end
          end
          ST_E4: begin
            if (at_b && cmd == KEY_DAT_B) begin
              st   <= ST_E5;
              mode <= mode;
            end
          end
          ST_E5: begin
            if (erase_ok) begin
              start_pulse <= 1'b1;
              start_op    <= erase_op;
              tgt_addr    <= erase_addr;
              tgt_data    <= wr_data;
            end
          end
          default: st <= ST_IDLE;
        endcase
      end
    end
  end

endmodule

// File: rtl/nor_cmd_decoder.sv
module nor_cmd_decoder
  import nor_cmd_pkg::*;
#(
  parameter int ADDR_W   = 19,
  parameter int DATA_W   = 16,
  parameter int SECT_LSB = 11,
  parameter int BLK_LSB  = 15
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              ce_n,
  input  logic              we_n,
  input  logic              oe_n,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] data,
  input  logic              busy,
  output logic              start_pulse,
  output logic [1:0]        start_op,
  output logic [ADDR_W-1:0] tgt_addr,
  output logic [DATA_W-1:0] tgt_data,
  output logic [1:0]        mode
);

  logic              wr_vld;
  logic [ADDR_W-1:0] wr_addr;
  logic [DATA_W-1:0] wr_data;
  op_e               op_q;
  mode_e             mode_q;

  nor_bus_sampler #(
    .ADDR_W(ADDR_W),
    .DATA_W(DATA_W)
  ) u_sampler (
    .clk    (clk),
    .rst    (rst),
    .ce_n   (ce_n),
    .we_n   (we_n),
    .oe_n   (oe_n),
    .addr   (addr),
    .data   (data),
    .wr_vld (wr_vld),
    .wr_addr(wr_addr),
    .wr_data(wr_data)
  );

  nor_seq_fsm #(
    .ADDR_W  (ADDR_W),
    .DATA_W  (DATA_W),
    .SECT_LSB(SECT_LSB),
    .BLK_LSB (BLK_LSB)
  ) u_fsm (
    .clk        (clk),
    .rst        (rst),
    .wr_vld     (wr_vld),
    .wr_addr    (wr_addr),
    .wr_data    (wr_data),
    .busy       (busy),
    .start_pulse(start_pulse),
    .start_op   (op_q),
    .tgt_addr   (tgt_addr),
    .tgt_data   (tgt_data),
    .mode       (mode_q)
  );

  assign start_op = op_q;
  assign mode     = mode_q;

endmodule

// File: rtl/nor_cmd_decoder_chk.sv
module nor_cmd_decoder_chk #(
  parameter int ADDR_W   = 19,
  parameter int SECT_LSB = 11,
  parameter int BLK_LSB  = 15
) (
  input logic              clk,
  input logic              rst,
  input logic              busy,
  input logic              start_pulse,
  input logic [1:0]        start_op,
  input logic [ADDR_W-1:0] tgt_addr,
  input logic [1:0]        mode
);

  // R1
  reset_state_chk: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (mode == 2'b00 && !start_pulse));

  // R12
  pulse_single_chk: assert property (@(posedge clk) disable iff (rst)
    start_pulse |=> !start_pulse);

  // R9
  busy_no_start_chk: assert property (@(posedge clk) disable iff (rst)
    start_pulse |-> !$past(busy));

  // R9
  busy_mode_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (mode != $past(mode)) |-> !$past(busy));

  // R6
  mode_legal_chk: assert property (@(posedge clk) disable iff (rst)
    mode != 2'b11);

  // R5
  sect_align_chk: assert property (@(posedge clk) disable iff (rst)
    (start_pulse && start_op == 2'b01) |-> (tgt_addr[SECT_LSB-1:0] == '0));

  // R5
  blk_align_chk: assert property (@(posedge clk) disable iff (rst)
    (start_pulse && start_op == 2'b10) |-> (tgt_addr[BLK_LSB-1:0] == '0));

  // R4
  chip_zero_chk: assert property (@(posedge clk) disable iff (rst)
    (start_pulse && start_op == 2'b11) |-> (tgt_addr == '0));

endmodule

bind nor_cmd_decoder nor_cmd_decoder_chk #(
  .ADDR_W  (ADDR_W),
  .SECT_LSB(SECT_LSB),
  .BLK_LSB (BLK_LSB)
) u_chk (
  .clk        (clk),
  .rst        (rst),
  .busy       (busy),
  .start_pulse(start_pulse),
  .start_op   (start_op),
  .tgt_addr   (tgt_addr),
  .mode       (mode)
);

// File: tb/nor_cmd_decoder_bench.sv
module nor_cmd_decoder_bench;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        ce_n = 1'b1, we_n = 1'b1, oe_n = 1'b1;
  logic [18:0] addr = '0;
  logic [15:0] data = '0;
  logic        busy = 1'b0;
  logic        start_pulse;
  logic [1:0]  start_op;
  logic [18:0] tgt_addr;
  logic [15:0] tgt_data;
  logic [1:0]  mode;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  logic [1:0]  q_op[$];
  logic [18:0] q_addr[$];
  logic [15:0] q_data[$];
  string       q_tag[$];
  string       cur_tag = "R1";

  always #5 clk = ~clk;

  nor_cmd_decoder u_nor_cmd_decoder (
    .clk(clk), .rst(rst), .ce_n(ce_n), .we_n(we_n), .oe_n(oe_n),
    .addr(addr), .data(data), .busy(busy),
    .start_pulse(start_pulse), .start_op(start_op),
    .tgt_addr(tgt_addr), .tgt_data(tgt_data), .mode(mode)
  );

  task automatic expect_op(input logic [1:0] op, input logic [18:0] a,
                           input logic [15:0] d, input string tag);
    q_op.push_back(op);
    q_addr.push_back(a);
    q_data.push_back(d);
    q_tag.push_back(tag);
  endtask

  task automatic wr_oe(input logic [18:0] a, input logic [15:0] d, input logic oe);
    @(negedge clk);
    addr = a; data = d; ce_n = 1'b0; oe_n = oe;
    @(negedge clk); we_n = 1'b0;
    @(negedge clk);
    @(negedge clk); we_n = 1'b1;
    @(negedge clk); ce_n = 1'b1; oe_n = 1'b1;
    repeat (4) @(negedge clk);
  endtask

  task automatic wr(input logic [18:0] a, input logic [15:0] d);
    wr_oe(a, d, 1'b1);
  endtask

  task automatic unlock3(input logic [7:0] c);
    wr(19'h05555, 16'h00AA);
    wr(19'h02AAA, 16'h0055);
    wr(19'h05555, {8'h00, c});
  endtask

  task automatic erase_prefix;
    unlock3(8'h80);
    wr(19'h05555, 16'h00AA);
    wr(19'h02AAA, 16'h0055);
  endtask

  task automatic chk_mode(input logic [1:0] exp, input string tag);
    checks++;
    if (mode !== exp) begin
      errors++;
      $display("FAIL %s mode actual %0h expected %0h", tag, mode, exp);
    end
  endtask

  task automatic chk_drained(input string tag);
    checks++;
    if (q_op.size() != 0) begin
      errors++;
      $display("FAIL %s pending starts actual %0d expected 0", tag, q_op.size());
    end
  endtask

  // monitor: scoreboard pop on every start pulse
  logic prev_pulse = 1'b0;
  always @(negedge clk) begin
    if (!rst) begin
      if (prev_pulse) begin
        checks++;
        if (start_pulse) begin
          errors++;
          $display("FAIL R12 pulse width actual 2+ expected 1");
        end
      end
      if (start_pulse && !prev_pulse) begin
        checks++;
        if (q_op.size() == 0) begin
          errors++;
          $display("FAIL %s unexpected start actual op %0h addr %0h expected none",
                   cur_tag, start_op, tgt_addr);
        end else begin
          logic [1:0]  eo;
          logic [18:0] ea;
          logic [15:0] ed;
          string       et;
          eo = q_op.pop_front();
          ea = q_addr.pop_front();
          ed = q_data.pop_front();
          et = q_tag.pop_front();
          if (start_op !== eo || tgt_addr !== ea || tgt_data !== ed) begin
            errors++;
            $display("FAIL %s start actual op %0h addr %0h data %0h expected op %0h addr %0h data %0h",
                     et, start_op, tgt_addr, tgt_data, eo, ea, ed);
          end
        end
      end
      prev_pulse = start_pulse;
    end
  end

  task automatic finish_run;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  initial begin
    #2_000_000;
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual hung expected finish");
      finish_run();
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);

    // R1: reset state, lone write starts nothing
    cur_tag = "R1";
    chk_mode(2'b00, "R1");
    checks++;
    if (start_pulse !== 1'b0) begin
      errors++;
      $display("FAIL R1 start_pulse actual %0b expected 0", start_pulse);
    end
    wr(19'h01234, 16'hBEEF);
    chk_mode(2'b00, "R1");

    // R3 + R2: program, unlock with junk upper address and data bits
    cur_tag = "R2";
    wr(19'h7D555, 16'h12AA);
    wr(19'h2AAAA, 16'hFF55);
    wr(19'h45555, 16'h33A0);
    expect_op(2'b00, 19'h12345, 16'hBEEF, "R3");
    wr(19'h12345, 16'hBEEF);
    chk_drained("R3");

    // R5: sector and block erase alignment
    cur_tag = "R5";
    erase_prefix();
    expect_op(2'b01, 19'h5A800, 16'h0030, "R5");
    wr(19'h5ABCD, 16'h0030);
    erase_prefix();
    expect_op(2'b10, 19'h58000, 16'h0050, "R5");
    wr(19'h5ABCD, 16'h0050);
    chk_drained("R5");

    // R4: chip erase, then wrong final address
    cur_tag = "R4";
    erase_prefix();
    expect_op(2'b11, 19'h00000, 16'h0010, "R4");
    wr(19'h05555, 16'h0010);
    erase_prefix();
    wr(19'h01234, 16'h0010);
    chk_drained("R4");
    chk_mode(2'b00, "R4");

    // R8: abort in the middle, then a clean program works
    cur_tag = "R8";
    wr(19'h05555, 16'h00AA);
    wr(19'h02AAB, 16'h0055);
    wr(19'h05555, 16'h00A0);
    wr(19'h00100, 16'h1111);
    chk_drained("R8");
    unlock3(8'hA0);
    expect_op(2'b00, 19'h00200, 16'h2222, "R8");
    wr(19'h00200, 16'h2222);
    chk_drained("R8");

    // R6 / R7: mode entry and both exits
    cur_tag = "R6";
    unlock3(8'h90);
    chk_mode(2'b01, "R6");
    cur_tag = "R7";
    wr(19'h3ABCD, 16'h00F0);
    chk_mode(2'b00, "R7");
    unlock3(8'h98);
    chk_mode(2'b10, "R6");
    unlock3(8'hF0);
    chk_mode(2'b00, "R7");
    wr(19'h00055, 16'h0098);
    chk_mode(2'b10, "R6");
    // R8: stray write in query mode aborts to read
    wr(19'h00777, 16'h0012);
    chk_mode(2'b00, "R8");

    // R9: busy drops exit and program sequences
    cur_tag = "R9";
    unlock3(8'h90);
    busy = 1'b1;
    wr(19'h00000, 16'h00F0);
    chk_mode(2'b01, "R9");
    unlock3(8'hA0);
    wr(19'h00300, 16'h3333);
    busy = 1'b0;
    chk_drained("R9");
    chk_mode(2'b01, "R9");
    // position was not moved while busy: a fresh exit works
    wr(19'h00000, 16'h00F0);
    chk_mode(2'b00, "R9");

    // R10: output-enable-low strobe in the middle is ignored
    cur_tag = "R10";
    wr(19'h05555, 16'h00AA);
    wr_oe(19'h00000, 16'h0000, 1'b0);
    wr(19'h02AAA, 16'h0055);
    wr(19'h05555, 16'h00A0);
    expect_op(2'b00, 19'h00400, 16'h4444, "R10");
    wr(19'h00400, 16'h4444);
    chk_drained("R10");

    // R11: address at window open, data at window close
    cur_tag = "R11";
    unlock3(8'hA0);
    expect_op(2'b00, 19'h06660, 16'hD222, "R11");
    @(negedge clk);
    ce_n = 1'b0; oe_n = 1'b1; addr = 19'h01110; data = 16'hD111;
    @(negedge clk);
    addr = 19'h06660; we_n = 1'b0;
    @(negedge clk);
    addr = 19'h07770; data = 16'hD222;
    @(negedge clk);
    @(negedge clk);
    we_n = 1'b1;
    @(negedge clk);
    addr = 19'h0; data = 16'h0;
    ce_n = 1'b1;
    repeat (4) @(negedge clk);
    chk_drained("R11");

    repeat (5) @(negedge clk);
    done = 1'b1;
    finish_run();
  end

endmodule